// File: doc/BRIEF.md
# Two-Address Register File with Microcode Address Override

This block is the register storage of a microprogrammed datapath. It holds sixteen words. The lower eight are the registers an instruction can name. The upper eight are scratch slots that only the microcode can reach. Entry 0 always reads as zero, and writes to it have no effect. Four of the scratch slots are reserved by convention: entry 12 holds the source address, 13 the source data, 14 the destination address and 15 the destination data. In the hardware these four behave like any other storage word.

The file uses two addresses. One address, called the A/D address, selects both the write target and the first read port. The second address selects the other read port. A mode input decides where both addresses come from: either the 4-bit fields of the current microinstruction, or the 3-bit source and destination fields of the instruction, zero-extended. In instruction mode, a routing input chooses which instruction field feeds the A/D address. This allows a result to be written to the register named by the source field, and the destination register to be read as an operand.

Top module: `regfile_2addr`

## Requirements
- R1: With `wr_en` high at a rising clock edge (outside reset), `wr_data` is stored in the entry selected by the A/D address. A read of that entry from the next cycle on returns the stored value. The data width is the parameter `DATA_W`, 16 by default.
- R2: Entry 0 reads as zero on both read ports at all times. A write addressed to entry 0 changes nothing.
- R3: With `use_micro` = 1, the A/D address is `mi_ad` and the B address is `mi_b`, both 4 bits wide. All 16 entries can be reached, including hidden entries 8 to 15. Entries 12, 13, 14 and 15 store and return data like any other entry.
- R4: With `use_micro` = 0 and `ad_from_src` = 0, the A/D address is {0, `ir_dst`} and the B address is {0, `ir_src`}. Entries 8 to 15 are neither read nor written in this mode.
- R5: With `use_micro` = 0 and `ad_from_src` = 1, the A/D address is {0, `ir_src`} and the B address is {0, `ir_dst`}. A write therefore lands in the entry named by `ir_src`.
- R6: Both read ports are combinational. A read of an entry in the cycle it is being written returns the value it held before that edge.
- R7: A synchronous active-high `rst` clears every entry to zero, and `wr_en` has no effect while `rst` is high.
- R8: At an edge with `wr_en` low, no entry changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the A/D entry |
| use_micro | input | 1 | 1: microinstruction fields drive the addresses; 0: instruction fields |
| ad_from_src | input | 1 | Instruction mode only: 1 routes `ir_src` to A/D and `ir_dst` to B |
| ir_src | input | 3 | Source register field of the instruction |
| ir_dst | input | 3 | Destination register field of the instruction |
| mi_ad | input | 4 | Microinstruction A/D register address |
| mi_b | input | 4 | Microinstruction B register address |
| wr_data | input | DATA_W | Write data |
| rd_a | output | DATA_W | Read data from the A/D address |
| rd_b | output | DATA_W | Read data from the B address |

## Verification
The bench builds the block with its defaults: 16-bit data, sixteen entries and 3-bit instruction fields. With these values every entry, including the four reserved scratch slots, can be written and read back through the microinstruction addresses, and a reference model checks each value. The 3-bit fields make the zero-extension boundary visible. Instruction field 4 must reach entry 4 and never entry 12, and the bench checks this by reading the hidden entries afterwards. It also checks the read-before-write value during every write cycle.

// File: rtl/regfile_2addr_pkg.sv
`timescale 1ns/1ps
package regfile_2addr_pkg;
  // reserved microcode scratch slots
  localparam int unsigned SLOT_SRC_ADDR = 12;
  localparam int unsigned SLOT_SRC_DATA = 13;
  localparam int unsigned SLOT_DST_ADDR = 14;
  localparam int unsigned SLOT_DST_DATA = 15;

  typedef enum logic {ADDR_FROM_INSTR = 1'b0, ADDR_FROM_MICRO = 1'b1} addr_origin_e;
endpackage

// File: rtl/regfile_2addr_addr_sel.sv
`timescale 1ns/1ps
module regfile_2addr_addr_sel #(
  parameter int unsigned IFLD_W = 3,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_micro,
  input  logic              ad_from_src,
  input  logic [IFLD_W-1:0] ir_src,
  input  logic [IFLD_W-1:0] ir_dst,
  input  logic [ADDR_W-1:0] mi_ad,
  input  logic [ADDR_W-1:0] mi_b,
  output logic [ADDR_W-1:0] ad_addr,
  output logic [ADDR_W-1:0] b_addr
);
  import regfile_2addr_pkg::*;

  localparam int unsigned EXT_W = ADDR_W - IFLD_W;

  function automatic logic [ADDR_W-1:0] zext(input logic [IFLD_W-1:0] f);
    return {{EXT_W{1'b0}}, f};
  endfunction

  addr_origin_e origin;
  logic [ADDR_W-1:0] instr_ad, instr_b;

  assign origin   = addr_origin_e'(use_micro);
  assign instr_ad = ad_from_src ? zext(ir_src) : zext(ir_dst);
  assign instr_b  = ad_from_src ? zext(ir_dst) : zext(ir_src);

  // one 2:1 multiplexer per address bit
  for (genvar k = 0; k < ADDR_W; k++) begin : g_bitmux
    assign ad_addr[k] = (origin == ADDR_FROM_MICRO) ? mi_ad[k] : instr_ad[k];
    assign b_addr[k]  = (origin == ADDR_FROM_MICRO) ? mi_b[k]  : instr_b[k];
  end

  // R4
  instr_hidden_unreachable_chk: assert property (@(posedge clk) disable iff (rst)
    !use_micro |-> (ad_addr < ADDR_W'(1 << IFLD_W)) && (b_addr < ADDR_W'(1 << IFLD_W)));

  // R5
  instr_ports_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_micro && ir_src != ir_dst) |-> (ad_addr != b_addr));
endmodule

// File: rtl/regfile_2addr_store.sv
`timescale 1ns/1ps
module regfile_2addr_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] ad_addr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [NREG-1:0][DATA_W-1:0] q;
  logic                        wr_fire;

  // named event: a write that actually lands
  assign wr_fire = wr_en && !rst && (ad_addr != '0);

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign q[i] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                                       r <= '0;
        else if (wr_en && ad_addr == ADDR_W'(i))       r <= wr_data;
      end
      assign q[i] = r;
    end
  end

  assign rd_a = q[ad_addr];
  assign rd_b = q[b_addr];

  // R2
  zero_entry_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((ad_addr == '0) |-> (rd_a == '0)) and ((b_addr == '0) |-> (rd_b == '0)));

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (q[$past(ad_addr)] == $past(wr_data)));

  // R8
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/regfile_2addr.sv
`timescale 1ns/1ps
module regfile_2addr #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREG   = 16,
  parameter int unsigned IFLD_W = 3,
  localparam int unsigned ADDR_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              use_micro,
  input  logic              ad_from_src,
  input  logic [IFLD_W-1:0] ir_src,
  input  logic [IFLD_W-1:0] ir_dst,
  input  logic [ADDR_W-1:0] mi_ad,
  input  logic [ADDR_W-1:0] mi_b,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [ADDR_W-1:0] ad_addr, b_addr;

  regfile_2addr_addr_sel #(.IFLD_W(IFLD_W), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .use_micro(use_micro), .ad_from_src(ad_from_src),
    .ir_src(ir_src), .ir_dst(ir_dst), .mi_ad(mi_ad), .mi_b(mi_b),
    .ad_addr(ad_addr), .b_addr(b_addr)
  );

  regfile_2addr_store #(.DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ad_addr(ad_addr), .b_addr(b_addr),
    .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b)
  );

  // R3
  micro_routes_chk: assert property (@(posedge clk) disable iff (rst)
    (use_micro && mi_ad == mi_b) |-> (rd_a == rd_b));
endmodule

// File: tb/test_regfile_2addr.sv
`timescale 1ns/1ps
module test_regfile_2addr;
  localparam int DW = 16;

  logic clk = 0, rst = 1, wr_en = 0, use_micro = 1, ad_from_src = 0;
  logic [2:0] ir_src = 0, ir_dst = 0;
  logic [3:0] mi_ad = 0, mi_b = 0;
  logic [DW-1:0] wr_data = 0, rd_a, rd_b;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] model [16];

  always #2.5 clk = ~clk;

  regfile_2addr i_regfile_2addr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .use_micro(use_micro), .ad_from_src(ad_from_src),
    .ir_src(ir_src), .ir_dst(ir_dst), .mi_ad(mi_ad), .mi_b(mi_b),
    .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b)
  );

  function automatic logic [3:0] exp_ad();
    if (use_micro) return mi_ad;
    return {1'b0, ad_from_src ? ir_src : ir_dst};
  endfunction
  function automatic logic [3:0] exp_b();
    if (use_micro) return mi_b;
    return {1'b0, ad_from_src ? ir_dst : ir_src};
  endfunction

  task automatic cmp(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    #1;
    cmp(req, rd_a, model[exp_ad()]);
    cmp(req, rd_b, model[exp_b()]);
  endtask

  // one write at the current address settings; checks old value during the write cycle (R6)
  task automatic do_write(input logic [DW-1:0] d, input string req);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    #1 cmp("R6", rd_a, model[exp_ad()]);
    @(posedge clk);
    if (exp_ad() != 0) model[exp_ad()] = d;
    @(negedge clk);
    wr_en = 0;
    check_ports(req);
  endtask

  task automatic dump_all(input string req);
    use_micro = 1;
    for (int i = 0; i < 16; i++) begin
      mi_ad = 4'(i); mi_b = 4'(15 - i);
      check_ports(req);
    end
  endtask

  task automatic t_reset();
    rst = 1; wr_en = 1; wr_data = 16'hDEAD; use_micro = 1; mi_ad = 4'd7;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; wr_en = 0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    dump_all("R7");
  endtask

  task automatic t_micro_fill();
    use_micro = 1;
    for (int i = 0; i < 16; i++) begin
      mi_ad = 4'(i); mi_b = 4'((i + 3) % 16);
      do_write(16'h1000 + 16'(i * 16'h0111), i >= 8 ? "R3" : "R1");
    end
    dump_all("R3");
    mi_ad = 0; mi_b = 0; #1;
    cmp("R2", rd_a, '0); cmp("R2", rd_b, '0);
    // reserved slots are plain storage
    mi_ad = 4'(regfile_2addr_pkg::SLOT_SRC_ADDR); do_write(16'hA5A5, "R3");
    mi_ad = 4'(regfile_2addr_pkg::SLOT_DST_DATA); do_write(16'h5A5A, "R3");
  endtask

  task automatic t_instr();
    use_micro = 0; ad_from_src = 0;
    for (int s = 0; s < 8; s++) begin
      ir_src = 3'(s); ir_dst = 3'(7 - s);
      check_ports("R4");
    end
    ir_dst = 3'd4; ir_src = 3'd5;
    do_write(16'hBEEF, "R4");
    ir_dst = 3'd0;
    do_write(16'hFFFF, "R2");
    dump_all("R4");
  endtask

  task automatic t_swap();
    use_micro = 0; ad_from_src = 1;
    ir_src = 3'd6; ir_dst = 3'd2;
    check_ports("R5");
    do_write(16'h0C0C, "R5");
    use_micro = 1; mi_ad = 4'd6; mi_b = 4'd2; #1;
    cmp("R5", rd_a, 16'h0C0C);
    cmp("R5", rd_b, model[2]);
    ad_from_src = 0;
  endtask

  task automatic t_hold();
    use_micro = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_en = 0; mi_ad = 4'(i + 9); wr_data = 16'h7777 + 16'(i);
      @(posedge clk);
    end
    @(negedge clk);
    dump_all("R8");
  endtask

  initial begin
    #150000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_micro_fill();
    t_instr();
    t_swap();
    t_hold();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule